// File: doc/BRIEF.md
# Banked Memory Collision Resolver

This block sits between a set of simple cores and a word-interleaved array of memory banks and replaces any request buffering with immediate arbitration. In each clock cycle every core may present one read or write, given as a valid bit, a write enable, a byte address and write data. Consecutive 32-bit words belong to consecutive banks, so the bank is chosen by the address bits directly above the two byte-offset bits. The block gathers every request that lands on a given bank and grants one of them. If that winner is a read, every other read of the same word in that cycle is served with it. Every other requester receives a negative acknowledge, and that core has to issue the request again.

Each request gets a response exactly two clock edges after it was presented: one edge to reach the banks and one to come back. The response carries a valid flag, the grant or refusal, and the read data. The block holds no queue. A refused request leaves no state behind, apart from the per-bank fairness pointer, which moves only on a grant. The bank count is a power-of-two parameter (64 by default, with 128, 256 and 512 also supported), as are the core count and the address and data widths.

Top module: `bankmesh_resolver`

## Requirements
- R1: For a request, the bank is byte-address bits [2 +: log2(N_BANKS)], the row inside that bank is the bits above them, and the word address is every bit above the two offset bits. Requests to different banks in the same cycle never affect each other's grant or data.
- R2: Every request presented with req_valid high gets exactly one response with rsp_valid high, two rising clock edges later. A refused request is not kept or replayed by the block.
- R3: A request that is the only one to its bank in its cycle is always granted.
- R4: When several requests target one bank in a cycle, at least one of them is granted, and rsp_ack is never high without rsp_valid.
- R5: When a bank's winner is a read, every other read in that cycle with the same word address (byte-offset bits ignored) is also granted and returns the same data.
- R6: When a bank's winner is a write, it is the only request granted in that bank. A write is never merged with another request.
- R7: Each bank has a round-robin pointer that resets to 0. The winner is the first requesting core at or after the pointer, wrapping around the core indices. After a grant the pointer moves to the winner plus one, modulo the core count.
- R8: A granted write updates the bank at the edge that produces its response, so a read presented in the next cycle returns the new value. A refused write leaves the storage unchanged.
- R9: When rsp_valid is high, rsp_rdata holds the bank word for a granted read and zero for a granted write or a refusal.
- R10: While reset is asserted, and until the first response, rsp_valid and rsp_ack are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | N_CORES | Request present, one bit per core |
| req_we | input | N_CORES | 1 = write, 0 = read, one bit per core |
| req_addr | input | N_CORES*ADDR_W | Byte addresses; core i uses bits [i*ADDR_W +: ADDR_W] |
| req_wdata | input | N_CORES*DATA_W | Write data; core i uses bits [i*DATA_W +: DATA_W] |
| rsp_valid | output | N_CORES | Response present, two edges after the request |
| rsp_ack | output | N_CORES | 1 = granted, 0 = refused (retry needed) |
| rsp_rdata | output | N_CORES*DATA_W | Read data for granted reads, zero otherwise |

## Verification
The bench goes after four corners. The first is reads that reach the same word through different byte offsets; a resolver that compares full byte addresses would refuse one of them. The second is a write contending with reads of the same word; merging the reads onto a write winner would return stale data and break write exclusivity. The third is wrap-around of the fairness pointer when all cores hit one bank; a pointer that does not advance, or that advances on an empty cycle, starves the higher-numbered cores. The fourth is a read issued directly behind a write to the same word; mistimed storage updates would return the old value. Each pattern is checked against a bench model of the winner selection, the pointer and the memory contents.

// File: rtl/bmr_pkg.sv
package bmr_pkg;

  // Modular increment used by the fairness pointers.
  function automatic int wrap_add(input int base, input int step, input int modulus);
    int sum;
    sum = base + step;
    if (sum >= modulus) sum = sum - modulus;
    return sum;
  endfunction

endpackage

// File: rtl/bmr_rr_pick.sv
module bmr_rr_pick
  import bmr_pkg::*;
#(
  parameter int N_REQ = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req,
  output logic [IDX_W-1:0] grant_idx,
  output logic             grant_any
);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] ptr_d;
  logic             ptr_en;

  // First requester at or after the pointer, wrapping.
  always_comb begin
    grant_any = 1'b0;
    grant_idx = '0;
    for (int k = 0; k < N_REQ; k++) begin
      if (!grant_any && req[wrap_add(int'(ptr_q), k, N_REQ)]) begin
        grant_any = 1'b1;
        grant_idx = IDX_W'(wrap_add(int'(ptr_q), k, N_REQ));
      end
    end
  end

  always_comb begin
    ptr_en = grant_any;
    ptr_d  = IDX_W'(wrap_add(int'(grant_idx), 1, N_REQ));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

endmodule

// File: rtl/bmr_bank_store.sv
module bmr_bank_store #(
  parameter int DATA_W = 32,
  parameter int ROW_W  = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ROW_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      cells[row] <= wr_data;
    end
  end

  assign rd_data = cells[row];

endmodule

// File: rtl/bankmesh_resolver.sv
module bankmesh_resolver #(
  parameter int N_CORES = 16,
  parameter int N_BANKS = 64,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_CORES-1:0]          req_valid,
  input  logic [N_CORES-1:0]          req_we,
  input  logic [N_CORES*ADDR_W-1:0]   req_addr,
  input  logic [N_CORES*DATA_W-1:0]   req_wdata,
  output logic [N_CORES-1:0]          rsp_valid,
  output logic [N_CORES-1:0]          rsp_ack,
  output logic [N_CORES*DATA_W-1:0]   rsp_rdata
);

  localparam int BANK_W = $clog2(N_BANKS);
  localparam int WORD_W = ADDR_W - 2;
  localparam int ROW_W  = WORD_W - BANK_W;
  localparam int CORE_W = (N_CORES > 1) ? $clog2(N_CORES) : 1;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  // Stage 1: requests travel to the banks.
  logic [N_CORES-1:0] s1_valid_q;
  logic [N_CORES-1:0] s1_we_q;
  logic [WORD_W-1:0]  s1_word_q  [N_CORES];
  logic [DATA_W-1:0]  s1_wdata_q [N_CORES];
  logic [BANK_W-1:0]  s1_bank    [N_CORES];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      s1_valid_q <= '0;
    end else begin
      s1_valid_q <= req_valid;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_CORES; i++) begin
      if (req_valid[i]) begin
        s1_we_q[i]    <= req_we[i];
        s1_word_q[i]  <= req_addr[i*ADDR_W+2 +: WORD_W];
        s1_wdata_q[i] <= req_wdata[i*DATA_W +: DATA_W];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N_CORES; i++) begin
      s1_bank[i] = s1_word_q[i][BANK_W-1:0];
    end
  end

  // Per-bank arbitration and storage.
  logic [CORE_W-1:0] win_idx  [N_BANKS];
  logic [N_BANKS-1:0] win_any;
  logic [N_BANKS-1:0] win_we;
  logic [WORD_W-1:0] win_word [N_BANKS];
  logic [DATA_W-1:0] bank_rd  [N_BANKS];

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    logic [N_CORES-1:0] hit;
    logic [ROW_W-1:0]   win_row;

    always_comb begin
      for (int i = 0; i < N_CORES; i++) begin
        hit[i] = s1_valid_q[i] && (s1_bank[i] == BANK_W'(b));
      end
    end

    bmr_rr_pick #(
      .N_REQ (N_CORES),
      .IDX_W (CORE_W)
    ) pick_i (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .req       (hit),
      .grant_idx (win_idx[b]),
      .grant_any (win_any[b])
    );

    assign win_we[b]   = s1_we_q[win_idx[b]];
    assign win_word[b] = s1_word_q[win_idx[b]];
    assign win_row     = s1_word_q[win_idx[b]][WORD_W-1 -: ROW_W];

    bmr_bank_store #(
      .DATA_W (DATA_W),
      .ROW_W  (ROW_W)
    ) store_i (
      .clk     (clk),
      .wr_en   (win_any[b] && win_we[b]),
      .row     (win_row),
      .wr_data (s1_wdata_q[win_idx[b]]),
      .rd_data (bank_rd[b])
    );
  end

  // Grant decision per core: winner, or a read merged onto a read winner.
  logic [N_CORES-1:0] ack_d;
  logic [DATA_W-1:0]  data_d [N_CORES];

  always_comb begin
    for (int i = 0; i < N_CORES; i++) begin
      ack_d[i] = s1_valid_q[i] &&
                 ((win_idx[s1_bank[i]] == CORE_W'(i)) ||
                  (!win_we[s1_bank[i]] && !s1_we_q[i] &&
                   (s1_word_q[i] == win_word[s1_bank[i]])));
      data_d[i] = (ack_d[i] && !s1_we_q[i]) ? bank_rd[s1_bank[i]] : '0;
    end
  end

  // Stage 2: responses travel back.
  logic [N_CORES-1:0] rsp_valid_q;
  logic [N_CORES-1:0] rsp_ack_q;
  logic [DATA_W-1:0]  rsp_data_q [N_CORES];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rsp_valid_q <= '0;
      rsp_ack_q   <= '0;
    end else begin
      rsp_valid_q <= s1_valid_q;
      rsp_ack_q   <= ack_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_CORES; i++) begin
      if (s1_valid_q[i]) begin
        rsp_data_q[i] <= data_d[i];
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_ack   = rsp_ack_q;

  always_comb begin
    for (int i = 0; i < N_CORES; i++) begin
      rsp_rdata[i*DATA_W +: DATA_W] = rsp_data_q[i];
    end
  end

endmodule

// File: rtl/bmr_checker.sv
module bmr_checker #(
  parameter int N_CORES = 16,
  parameter int N_BANKS = 64,
  parameter int ADDR_W  = 12
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [N_CORES-1:0]        req_valid,
  input logic [N_CORES-1:0]        req_we,
  input logic [N_CORES*ADDR_W-1:0] req_addr,
  input logic [N_CORES-1:0]        rsp_valid,
  input logic [N_CORES-1:0]        rsp_ack
);

  localparam int BANK_W = $clog2(N_BANKS);
  localparam int WORD_W = ADDR_W - 2;

  logic [N_CORES-1:0] v1_q, v2_q, w1_q, w2_q;
  logic [WORD_W-1:0]  a1_q [N_CORES];
  logic [WORD_W-1:0]  a2_q [N_CORES];
  logic [1:0]         age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q  <= '0;
      v2_q  <= '0;
      w1_q  <= '0;
      w2_q  <= '0;
      age_q <= 2'd0;
      for (int i = 0; i < N_CORES; i++) begin
        a1_q[i] <= '0;
        a2_q[i] <= '0;
      end
    end else begin
      v1_q  <= req_valid;
      v2_q  <= v1_q;
      w1_q  <= req_we;
      w2_q  <= w1_q;
      age_q <= (age_q == 2'd2) ? 2'd2 : age_q + 2'd1;
      for (int i = 0; i < N_CORES; i++) begin
        a1_q[i] <= req_addr[i*ADDR_W+2 +: WORD_W];
        a2_q[i] <= a1_q[i];
      end
    end
  end

  logic               settled;
  logic [N_CORES-1:0] has_peer, peer_won, lone, orphan_nack, merge_miss;
  logic               write_shared;

  assign settled = (age_q == 2'd2);

  always_comb begin
    has_peer     = '0;
    peer_won     = '0;
    merge_miss   = '0;
    write_shared = 1'b0;
    for (int i = 0; i < N_CORES; i++) begin
      for (int j = 0; j < N_CORES; j++) begin
        if (j != i && v2_q[i] && v2_q[j] &&
            (a2_q[i][BANK_W-1:0] == a2_q[j][BANK_W-1:0])) begin
          has_peer[i] = 1'b1;
          if (rsp_ack[j]) peer_won[i] = 1'b1;
          if (rsp_ack[i] && rsp_ack[j] && (w2_q[i] || w2_q[j])) write_shared = 1'b1;
          if (!w2_q[i] && !w2_q[j] && (a2_q[i] == a2_q[j]) && rsp_ack[j] && !rsp_ack[i])
            merge_miss[i] = 1'b1;
        end
      end
    end
    lone        = v2_q & ~has_peer;
    orphan_nack = v2_q & ~rsp_ack & ~peer_won;
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    settled |-> (rsp_valid == v2_q));

  assert_lone_granted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    settled |-> ((lone & ~rsp_ack) == '0));

  assert_nack_has_winner_R4: assert property (@(posedge clk) disable iff (!rst_n)
    settled |-> (orphan_nack == '0));

  assert_ack_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ack & ~rsp_valid) == '0);

  assert_read_merge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    settled |-> (merge_miss == '0));

  assert_write_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
    settled |-> !write_shared);

  assert_quiet_in_reset_R10: assert property (@(posedge clk)
    !rst_n |-> (rsp_valid == '0));

endmodule

bind bankmesh_resolver bmr_checker #(
  .N_CORES (N_CORES),
  .N_BANKS (N_BANKS),
  .ADDR_W  (ADDR_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_we    (req_we),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_ack   (rsp_ack)
);

// File: tb/bankmesh_resolver_tb_top.sv
`timescale 1ns/1ps
module bankmesh_resolver_tb_top;

  localparam int NC = 4;
  localparam int NB = 4;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic [NC-1:0]    req_valid, req_we;
  logic [NC*AW-1:0] req_addr;
  logic [NC*DW-1:0] req_wdata;
  logic [NC-1:0]    rsp_valid, rsp_ack;
  logic [NC*DW-1:0] rsp_rdata;

  always #2.5 clk = ~clk;

  bankmesh_resolver #(
    .N_CORES (NC), .N_BANKS (NB), .ADDR_W (AW), .DATA_W (DW)
  ) dut_i (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_we (req_we),
    .req_addr (req_addr), .req_wdata (req_wdata),
    .rsp_valid (rsp_valid), .rsp_ack (rsp_ack), .rsp_rdata (rsp_rdata)
  );

  int n_vec = 0;
  int n_bad = 0;

  logic [DW-1:0] ref_mem [64];
  int            ptr_m [NB];
  logic [NC-1:0] t_v, t_we;
  logic [AW-1:0] t_a [NC];
  logic [DW-1:0] t_d [NC];
  logic [NC-1:0] e_ack;
  logic [DW-1:0] e_dat [NC];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive_idle();
    req_valid = '0; req_we = '0; req_addr = '0; req_wdata = '0;
  endtask

  task automatic drive_t();
    for (int i = 0; i < NC; i++) begin
      req_valid[i] = t_v[i];
      req_we[i]    = t_we[i];
      req_addr[i*AW +: AW]  = t_a[i];
      req_wdata[i*DW +: DW] = t_d[i];
    end
  endtask

  function automatic int bank_of(input logic [AW-1:0] a);
    return int'(a[3:2]);
  endfunction

  // Independent model of arbitration, pointers and storage.
  task automatic model();
    e_ack = '0;
    for (int i = 0; i < NC; i++) e_dat[i] = '0;
    for (int b = 0; b < NB; b++) begin
      int win;
      win = -1;
      for (int k = 0; k < NC; k++) begin
        int c;
        c = (ptr_m[b] + k) % NC;
        if (win < 0 && t_v[c] && bank_of(t_a[c]) == b) win = c;
      end
      if (win >= 0) begin
        ptr_m[b] = (win + 1) % NC;
        for (int i = 0; i < NC; i++) begin
          if (t_v[i] && bank_of(t_a[i]) == b &&
              (i == win || (!t_we[win] && !t_we[i] && t_a[i][AW-1:2] == t_a[win][AW-1:2]))) begin
            e_ack[i] = 1'b1;
            if (!t_we[i]) e_dat[i] = ref_mem[t_a[i][AW-1:2]];
          end
        end
        if (t_we[win]) ref_mem[t_a[win][AW-1:2]] = t_d[win];
      end
    end
  endtask

  // Present t_* for one cycle at a falling edge; sample after the second rising edge.
  task automatic apply(input string tag);
    model();
    drive_t();
    @(negedge clk);
    drive_idle();
    @(negedge clk);
    for (int i = 0; i < NC; i++) begin
      check({tag, " valid"}, rsp_valid[i], t_v[i]);
      check({tag, " ack"}, rsp_ack[i], e_ack[i]);
      if (t_v[i]) check({tag, " data"}, rsp_rdata[i*DW +: DW], e_dat[i]);
    end
  endtask

  task automatic clear_t();
    t_v = '0; t_we = '0;
    for (int i = 0; i < NC; i++) begin
      t_a[i] = '0; t_d[i] = '0;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    drive_idle();
    repeat (3) @(negedge clk);
    check("R10 valid in reset", rsp_valid, '0);
    check("R10 ack in reset", rsp_ack, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 valid after reset", rsp_valid, '0);
    for (int b = 0; b < NB; b++) ptr_m[b] = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int w = 0; w < 64; w++) ref_mem[w] = '0;
    clear_t();
    @(negedge clk);
    do_reset();

    // R8: write then read of the same word in back-to-back cycles.
    req_valid = 4'b0001; req_we = 4'b0001;
    req_addr[0 +: AW] = 8'h30; req_wdata[0 +: DW] = 16'hBEEF;
    @(negedge clk);
    drive_idle();
    req_valid = 4'b0010; req_addr[AW +: AW] = 8'h30;
    @(negedge clk);
    drive_idle();
    check("R8 write granted", rsp_ack, 4'b0001);
    @(negedge clk);
    check("R8 read granted", rsp_ack, 4'b0010);
    check("R8 read sees new value", rsp_rdata[DW +: DW], 16'hBEEF);
    ref_mem[12] = 16'hBEEF;
    ptr_m[0] = 2;

    // Fill every word from one core at a time (R3, R8).
    for (int w = 0; w < 64; w++) begin
      clear_t();
      t_v[w % NC] = 1'b1; t_we[w % NC] = 1'b1;
      t_a[w % NC] = AW'(w << 2);
      t_d[w % NC] = DW'(w * 291 + 7);
      apply("R3 R8 fill");
    end

    // Parallel reads, one bank per core (R1, R9).
    for (int g = 0; g < 16; g++) begin
      clear_t();
      for (int i = 0; i < NC; i++) begin
        t_v[i] = 1'b1;
        t_a[i] = AW'((4 * g + i) << 2);
      end
      apply("R1 R9 readback");
    end

    // Exhaustive sweep: 0 idle, 1 read 0x24, 2 read 0x27, 3 read 0x54, 4 write 0x24.
    for (int n = 0; n < 625; n++) begin
      int rem;
      rem = n;
      clear_t();
      for (int i = 0; i < NC; i++) begin
        int op;
        op = rem % 5;
        rem = rem / 5;
        t_v[i]  = (op != 0);
        t_we[i] = (op == 4);
        t_a[i]  = (op == 2) ? 8'h27 : (op == 3) ? 8'h54 : 8'h24;
        t_d[i]  = DW'(n * 4 + i);
      end
      apply("R4 R5 R6 R7 R9 sweep");
    end

    // Round robin from a fresh reset: all cores write one word.
    do_reset();
    for (int k = 0; k < 8; k++) begin
      clear_t();
      for (int i = 0; i < NC; i++) begin
        t_v[i] = 1'b1; t_we[i] = 1'b1; t_a[i] = 8'h24; t_d[i] = DW'(k * 16 + i);
      end
      apply("R7 rotate");
      check("R7 winner order", rsp_ack, 4'b0001 << (k % 4));
    end
    clear_t();
    t_v[2] = 1'b1; t_a[2] = 8'h26;
    apply("R8 last write");
    check("R8 refused writes left no trace", rsp_rdata[2*DW +: DW], 16'h0073);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule